// File: doc/BRIEF.md
# Scrambled-Map Vectored Interrupt Controller

The block collects 63 usable interrupt sources, numbered 1 to 63 (source 0 is reserved), into pending state. It gates that state with per-source enable bits and raises a single request line towards the processor. Software reaches it over a small synchronous register port with a word address, a write strobe, 32-bit write data and registered read data. Sources are active low. Every raw line passes through a two-flop synchronizer before its sense logic.

Pending and enable state is not laid out one bit per source number. Each source owns one bit in either an upper or a lower 32-bit word, at a fixed, non-arithmetic position. Software handles the pending words as write-one-to-clear. A sense-select word switches two source groups between falling-edge latching and active-low level sensing: the external group (19 to 25) and the port group (48 to 63). All other sources are always level sensed. A read-only vector word gives the lowest-numbered source that is both pending and enabled. Two further words are plain storage for priority configuration.

Top module: `vic_top`

## Requirements
- R1: After reset both enable words, both pending words, the sense-select word, both storage words and the vector word read zero, and irq_o is low while all source inputs are high.
- R2: Word addresses are 0 enable-upper, 1 enable-lower, 2 pending-upper, 3 pending-lower, 4 vector, 5 sense-select, 6 storage A, 7 storage B. Sources 16–31 and 48–63 use the upper words and all others use the lower words. The bit of source s is 0 for s=0, 16-s for s=1..15, 18-s for s=16..18, 33-s for s=19..30, 15 for s=31, 63-s for s=32..47 and s-32 for s=48..63.
- R3: A level-sensed source is pending exactly while its input is low. With its enable set, irq_o rises on the second rising clock edge after the input falls. Writing one to its pending bit does not clear it while the input stays low.
- R4: An edge-sensed source sets its pending bit on a high-to-low transition of its input. The bit stays set after the input returns high, until it is cleared.
- R5: Writing a 1 to a pending-word bit clears the latched pending state of an edge-sensed source. Writing a 0 leaves it unchanged.
- R6: In the sense-select word, bit 33-s selects the sense of source s for s=19..25, and bit 79-s selects it for s=48..63. A 1 means falling edge and a 0 means active-low level. All other bits read back zero and have no effect.
- R7: A source whose enable bit is 0 still shows in its pending word, but it neither raises irq_o nor appears in the vector.
- R8: The vector word holds in bits 31:26 the number of the lowest-numbered source that is both pending and enabled, with all other bits zero. It reads zero when there is no such source.
- R9: irq_o is high exactly when at least one source is both pending and enabled.
- R10: Source 0 is reserved and never becomes pending, whatever its input does.
- R11: Storage words A and B read back the last value written. Writes to the vector address have no effect.
- R12: Read data is registered: rdata_o shows the word addressed in the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Word address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| src_n_i | input | 64 | Raw active-low interrupt source lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong bit position in the source-to-word map shows up at the next read of a pending word as a bit in the wrong word or lane. If the map is not one-to-one, two sources also end up sharing one enable bit. A stuck or lost edge latch shows at the next pending read or vector read once the input has gone high again. A faulty priority scan shows as a wrong vector number while two or more enabled sources are pending. A fault in the synchronizer depth or reset value moves the irq_o rise away from the second edge, or makes a source look pending right after reset.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC = 64;
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int SW   = $clog2(NSRC);
    localparam int VEC_LSB = DW - SW;

    localparam logic [AW-1:0] A_EN_HI   = 3'd0;
    localparam logic [AW-1:0] A_EN_LO   = 3'd1;
    localparam logic [AW-1:0] A_PND_HI  = 3'd2;
    localparam logic [AW-1:0] A_PND_LO  = 3'd3;
    localparam logic [AW-1:0] A_VECTOR  = 3'd4;
    localparam logic [AW-1:0] A_SENSE   = 3'd5;
    localparam logic [AW-1:0] A_STORE_A = 3'd6;
    localparam logic [AW-1:0] A_STORE_B = 3'd7;

    localparam int EXT_FIRST  = 19;
    localparam int EXT_LAST   = 25;
    localparam int EXT_TOP    = 14;
    localparam int PORT_FIRST = 48;
    localparam int PORT_LAST  = 63;
    localparam int PORT_TOP   = 31;

    localparam logic [DW-1:0] SENSE_WMASK = 32'hFFFF_7F00;

    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] latch;
    } sense_state_t;

    typedef struct packed {
        logic [DW-1:0] en_hi;
        logic [DW-1:0] en_lo;
        logic [DW-1:0] sense;
        logic [DW-1:0] store_a;
        logic [DW-1:0] store_b;
        logic [DW-1:0] rdata;
    } vic_regs_t;

    // Which of the two words holds source s
    function automatic logic in_upper(input int s);
        return ((s / 16) % 2) == 1;
    endfunction

    // Bit lane of source s inside its word
    function automatic int lane_of(input int s);
        if (s == 0)       return 0;
        else if (s < 16)  return 16 - s;
        else if (s < 19)  return 18 - s;
        else if (s < 31)  return 33 - s;
        else if (s == 31) return 15;
        else if (s < 48)  return 63 - s;
        else              return s - 32;
    endfunction

    // Sense-select bit of source s, -1 when its sense is fixed
    function automatic int sense_lane(input int s);
        if (s >= EXT_FIRST && s <= EXT_LAST)   return EXT_TOP - (s - EXT_FIRST);
        if (s >= PORT_FIRST && s <= PORT_LAST) return PORT_TOP - (s - PORT_FIRST);
        return -1;
    endfunction

    function automatic logic [NSRC-1:0] words_to_src(input logic [DW-1:0] up_w,
                                                     input logic [DW-1:0] lo_w);
        logic [NSRC-1:0] v;
        int b;
        v = '0;
        for (int s = 0; s < NSRC; s++) begin
            b = lane_of(s);
            v[s] = in_upper(s) ? up_w[b[4:0]] : lo_w[b[4:0]];
        end
        return v;
    endfunction

    function automatic logic [DW-1:0] src_to_word(input logic [NSRC-1:0] v,
                                                  input logic upper);
        logic [DW-1:0] w;
        int b;
        w = '0;
        for (int s = 0; s < NSRC; s++) begin
            b = lane_of(s);
            if (in_upper(s) == upper) w[b[4:0]] = v[s];
        end
        return w;
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int             W       = 64,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/vic_sense.sv
module vic_sense
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lvl_n_i,
    input  logic [NSRC-1:0] edge_mode_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    localparam logic [NSRC-1:0] USABLE = ~{{(NSRC-1){1'b0}}, 1'b1};

    sense_state_t st_d, st_q;
    logic [NSRC-1:0] fall;

    assign fall = st_q.prev & ~lvl_n_i;

    always_comb begin
        st_d.prev  = lvl_n_i;
        st_d.latch = edge_mode_i & USABLE & ((st_q.latch & ~clr_i) | fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= '1;
            st_q.latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_pend
        if (s == 0) begin : g_rsv
            assign pend_o[s] = 1'b0;
        end else begin : g_src
            assign pend_o[s] = edge_mode_i[s] ? st_q.latch[s] : ~lvl_n_i[s];
        end
    end

    logic [NSRC-1:0] hold_now, clr_now;
    assign hold_now = edge_mode_i & st_q.latch & ~clr_i;
    assign clr_now  = clr_i & ~fall;

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_now != '0) |=> ((st_q.latch & $past(hold_now)) == $past(hold_now)));

    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now != '0) |=> ((st_q.latch & $past(clr_now)) == '0));

endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] active_i,
    output logic [SW-1:0]   num_o,
    output logic            any_o
);

    always_comb begin
        num_o = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            if (active_i[s]) num_o = SW'(s);
        end
    end

    assign any_o = |active_i[NSRC-1:1];

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    input  logic [NSRC-1:0] src_n_i,
    output logic            irq_o
);

    vic_regs_t regs_d, regs_q;

    logic [NSRC-1:0] lvl_n, edge_mode, clr, pend, en, active;
    logic [SW-1:0]   vec_num;
    logic            vec_any;
    logic [DW-1:0]   vec_word;

    vic_sync #(.W(NSRC), .STAGES(2), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_n_i),
        .q_o   (lvl_n)
    );

    vic_sense u_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_n_i     (lvl_n),
        .edge_mode_i (edge_mode),
        .clr_i       (clr),
        .pend_o      (pend)
    );

    vic_prio u_prio (
        .active_i (active),
        .num_o    (vec_num),
        .any_o    (vec_any)
    );

    always_comb begin
        int b;
        edge_mode = '0;
        for (int s = 0; s < NSRC; s++) begin
            b = sense_lane(s);
            if (b >= 0) edge_mode[s] = regs_q.sense[b[4:0]];
        end
    end

    assign en       = words_to_src(regs_q.en_hi, regs_q.en_lo);
    assign active   = pend & en;
    assign vec_word = {vec_num, {VEC_LSB{1'b0}}};
    assign clr      = words_to_src((we_i && addr_i == A_PND_HI) ? wdata_i : '0,
                                   (we_i && addr_i == A_PND_LO) ? wdata_i : '0);

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (addr_i)
                A_EN_HI:   regs_d.en_hi   = wdata_i;
                A_EN_LO:   regs_d.en_lo   = wdata_i;
                A_SENSE:   regs_d.sense   = wdata_i & SENSE_WMASK;
                A_STORE_A: regs_d.store_a = wdata_i;
                A_STORE_B: regs_d.store_b = wdata_i;
                default:   ;
            endcase
        end
        case (addr_i)
            A_EN_HI:   regs_d.rdata = regs_q.en_hi;
            A_EN_LO:   regs_d.rdata = regs_q.en_lo;
            A_PND_HI:  regs_d.rdata = src_to_word(pend, 1'b1);
            A_PND_LO:  regs_d.rdata = src_to_word(pend, 1'b0);
            A_VECTOR:  regs_d.rdata = vec_word;
            A_SENSE:   regs_d.rdata = regs_q.sense;
            A_STORE_A: regs_d.rdata = regs_q.store_a;
            A_STORE_B: regs_d.rdata = regs_q.store_b;
            default:   regs_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rdata_o = regs_q.rdata;
    assign irq_o   = vec_any;

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((regs_q.en_hi | regs_q.en_lo) != '0));

    // R8
    vec_is_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_any |-> (vec_num != '0 && active[vec_num]));

    // R8
    vec_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_any |-> ((active & ((NSRC'(1) << vec_num) - NSRC'(1))) == '0));

    // R10
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_n[0]) |=> !pend[0]);

endmodule

// File: tb/vic_top_test.sv
module vic_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [63:0] src_n;
    logic        irq;

    always #10 clk = ~clk;

    vic_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .src_n_i (src_n),
        .irq_o   (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] m_in, m_latch;
    logic [31:0] m_eh, m_el, m_sense, m_sa, m_sb;

    function automatic bit t_up(int s);
        return (s >= 16 && s < 32) || (s >= 48);
    endfunction

    function automatic int t_lane(int s);
        if (s == 0) return 0;
        if (s <= 15) return 16 - s;
        if (s <= 18) return 18 - s;
        if (s <= 30) return 33 - s;
        if (s == 31) return 15;
        if (s <= 47) return 63 - s;
        return s - 32;
    endfunction

    function automatic int t_slane(int s);
        if (s >= 19 && s <= 25) return 33 - s;
        if (s >= 48) return 79 - s;
        return -1;
    endfunction

    function automatic bit t_edge(int s);
        int b = t_slane(s);
        if (b < 0) return 1'b0;
        return m_sense[b];
    endfunction

    function automatic bit t_pend(int s);
        if (s == 0) return 1'b0;
        if (t_edge(s)) return m_latch[s];
        return !m_in[s];
    endfunction

    function automatic bit t_en(int s);
        logic [31:0] w = t_up(s) ? m_eh : m_el;
        return w[t_lane(s)];
    endfunction

    function automatic logic [31:0] t_pword(bit up);
        logic [31:0] w = '0;
        for (int s = 0; s < 64; s++)
            if (t_up(s) == up) w[t_lane(s)] = t_pend(s);
        return w;
    endfunction

    function automatic logic [31:0] t_vec();
        for (int s = 1; s < 64; s++)
            if (t_pend(s) && t_en(s)) return 32'(s) << 26;
        return 32'd0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_sense(logic [31:0] d);
        logic [63:0] olde;
        for (int s = 0; s < 64; s++) olde[s] = t_edge(s);
        m_sense = d & 32'hFFFF_7F00;
        for (int s = 0; s < 64; s++)
            if (!(olde[s] && t_edge(s))) m_latch[s] = 1'b0;
    endtask

    task automatic model_clr(bit up, logic [31:0] d);
        for (int s = 0; s < 64; s++)
            if (t_up(s) == up && d[t_lane(s)]) m_latch[s] = 1'b0;
    endtask

    task automatic model_in(logic [63:0] v);
        for (int s = 1; s < 64; s++)
            if (t_edge(s) && m_in[s] && !v[s]) m_latch[s] = 1'b1;
        m_in = v;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
        case (a)
            3'd0: m_eh = d;
            3'd1: m_el = d;
            3'd2: model_clr(1'b1, d);
            3'd3: model_clr(1'b0, d);
            3'd5: model_sense(d);
            3'd6: m_sa = d;
            3'd7: m_sb = d;
            default: ;
        endcase
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic setin(logic [63:0] v);
        @(negedge clk);
        model_in(v);
        src_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        rd(3'd2, d); check({tag, " pend upper"}, d, t_pword(1'b1));
        rd(3'd3, d); check({tag, " pend lower"}, d, t_pword(1'b0));
        rd(3'd4, d); check({tag, " vector"}, d, t_vec());
        check({tag, " R9 irq"}, 32'(irq), 32'(t_vec() != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lst[6] = '{17, 31, 40, 50, 1, 63};
        void'($urandom(32'd2024));
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; src_n = '1;
        m_in = '1; m_latch = '0; m_eh = '0; m_el = '0; m_sense = '0; m_sa = '0; m_sb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every word zero after reset
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset word", d, 32'd0);
        end
        check("R1 irq after reset", 32'(irq), 32'd0);

        wr(3'd0, '1); wr(3'd1, '1);

        // R10: reserved source 0
        setin(~64'd1);
        rd(3'd3, d); check("R10 src0 pending", d, 32'd0);
        check("R10 irq", 32'(irq), 32'd0);
        setin('1);

        // R3: two-edge latency on irq and level hold under W1C
        @(negedge clk);
        model_in(~(64'd1 << 5));
        src_n = ~(64'd1 << 5);
        @(negedge clk);
        check("R3 irq after one edge", 32'(irq), 32'd0);
        @(negedge clk);
        check("R3 irq after two edges", 32'(irq), 32'd1);
        rd(3'd3, d); check("R3 level pending lane", d, 32'h0000_0800);
        rd(3'd4, d); check("R8 vector src5", d, 32'd5 << 26);
        wr(3'd3, 32'h0000_0800);
        rd(3'd3, d); check("R3 W1C no effect on level", d, 32'h0000_0800);
        setin('1);
        check_all("R3 released");

        // R2: source-to-lane map
        foreach (lst[i]) begin
            setin(~(64'd1 << lst[i]));
            rd(3'd2, d);
            check("R2 upper word", d, t_up(lst[i]) ? (32'd1 << t_lane(lst[i])) : 32'd0);
            rd(3'd3, d);
            check("R2 lower word", d, t_up(lst[i]) ? 32'd0 : (32'd1 << t_lane(lst[i])));
            rd(3'd4, d);
            check("R8 vector single", d, 32'(lst[i]) << 26);
        end
        setin('1);

        // R6 / R4 / R5: external source 21 (sense bit 12, upper lane 12)
        wr(3'd5, 32'h0000_1000);
        setin(~(64'd1 << 21));
        setin('1);
        rd(3'd2, d); check("R4 ext edge latched", d, 32'h0000_1000);
        wr(3'd2, 32'h0000_0000);
        rd(3'd2, d); check("R5 write zero keeps", d, 32'h0000_1000);
        wr(3'd2, 32'h0000_1000);
        rd(3'd2, d); check("R5 write one clears", d, 32'h0000_0000);

        // R6 / R4: port source 55 (sense bit 24, upper lane 23)
        wr(3'd5, 32'h0100_0000);
        setin(~(64'd1 << 55));
        setin('1);
        rd(3'd2, d); check("R4 port edge latched", d, 32'h0080_0000);
        rd(3'd4, d); check("R8 vector port", d, 32'd55 << 26);
        wr(3'd2, 32'h0080_0000);

        // R6: fixed bits read zero; internal source 10 stays level
        wr(3'd5, '1);
        rd(3'd5, d); check("R6 sense readback", d, 32'hFFFF_7F00);
        setin(~(64'd1 << 10));
        setin('1);
        rd(3'd3, d); check("R6 internal stays level", d, 32'd0);
        wr(3'd5, 32'd0);

        // R7: disabled source pending but silent; R8 priority order
        setin(~((64'd1 << 40) | (64'd1 << 9)));
        rd(3'd4, d); check("R8 lowest wins", d, 32'd9 << 26);
        wr(3'd1, ~(32'd1 << 7));
        rd(3'd4, d); check("R7 masked skipped", d, 32'd40 << 26);
        wr(3'd1, 32'd0);
        rd(3'd3, d); check("R7 pending visible", d, 32'h0080_0080);
        check("R7 irq low", 32'(irq), 32'd0);
        setin('1);

        // R11 storage, R12 registered read
        wr(3'd6, 32'h0530_9770);
        wr(3'd7, 32'hA5A5_0F0F);
        wr(3'd4, 32'hFC00_0000);
        rd(3'd6, d); check("R11 store A", d, 32'h0530_9770);
        rd(3'd7, d); check("R11 store B", d, 32'hA5A5_0F0F);
        rd(3'd4, d); check("R11 vector write ignored", d, 32'd0);
        @(negedge clk); addr = 3'd6;
        @(posedge clk); #1;
        addr = 3'd7;
        #2;
        check("R12 read data follows previous address", rdata, 32'h0530_9770);

        // Random mix
        for (int it = 0; it < 48; it++) begin
            if (it % 4 == 0) wr(3'd5, $urandom);
            wr(3'd0, $urandom);
            wr(3'd1, $urandom);
            setin({$urandom, $urandom});
            if ($urandom % 2) wr(($urandom % 2) ? 3'd2 : 3'd3, $urandom);
            check_all("R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule